// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable, reduced-depth model of a synchronous static RAM with a pipelined read path, a two-bit burst counter and byte-granular writes. Every input (address, write data, strobes, chip selects and write controls) is captured on the rising clock edge. A burst begins when either of two start strobes loads a base address. An advance input then steps an internal two-bit counter that forms the low two address bits for up to four beats. A mode pin picks linear or interleaved beat order.

Each word is 36 bits wide, made of four 9-bit lanes. A write can update any subset of the lanes, or all of them through the global write control. Read data for an address registered at one edge appears after the following edge. The model has separate data buses. High impedance on the output is shown as a low drive-enable output, `dout_en`. That output falls one cycle after a deselect is registered, and output enable gates it at any time, without waiting for a clock.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the burst counter is 0, no read result is pending and `dout_en` is 0.
- R2: A read registered at edge N has its word on `dout` with `dout_en`=1 after edge N+1, provided `oe_n` is 0.
- R3: With `ilv_mode`=0, beat k of a burst from base B addresses {B[AW-1:2], (B[1:0]+k) mod 4}.
- R4: With `ilv_mode`=1, beat k of a burst from base B addresses {B[AW-1:2], B[1:0] XOR k}.
- R5: With no start strobe active, `adv_n`=0 steps the counter by one and wraps 3 to 0. With `adv_n`=1 the address is held, so the same word is accessed again.
- R6: With `all_wr_n`=1 and `byte_wr_n`=0, lane i (bits 9i+8..9i) is written exactly when `lane_wr_n[i]`=0. The other lanes keep their contents.
- R7: `all_wr_n`=0 writes all four lanes, regardless of `byte_wr_n` and `lane_wr_n`.
- R8: With `all_wr_n`=1 and `byte_wr_n`=1 the cycle is a read and the array is unchanged.
- R9: A start strobe is a selected access only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Otherwise it is a deselect, and `dout_en` is 0 after the next edge.
- R10: `oe_n`=1 forces `dout_en` to 0 combinationally. Returning it to 0 restores a pending read result without a clock edge.
- R11: A word written in one cycle and read in the next cycle returns the new data.
- R12: `start_ctl_n` and `start_cpu_n` each load the base address and clear the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Base address, loaded on a start strobe |
| din | input | 36 | Write data, four 9-bit lanes |
| start_ctl_n | input | 1 | Start strobe from the controller, active low |
| start_cpu_n | input | 1 | Start strobe from the processor, active low |
| adv_n | input | 1 | Burst advance, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| dout | output | 36 | Read data |
| dout_en | output | 1 | Output drive enable; 0 represents high impedance |

## Verification
A counter or base register that goes wrong shows up as a wrong word on `dout` one edge after the beat that used it, so every beat of every burst is compared against an arithmetic address model in both orders and from every start offset. A write mask held wrongly in its register corrupts lanes that a read in the very next cycle exposes, so every lane pattern is written and then read back at once. A stale valid flag shows up as `dout_en` staying high one edge after a deselect or a write, which the bench checks on every cycle.

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int DEPTH = 64,
  parameter int BW    = 9,
  parameter int NB    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = BW * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  input  logic          start_ctl_n,
  input  logic          start_cpu_n,
  input  logic          adv_n,
  input  logic          byte_wr_n,
  input  logic          all_wr_n,
  input  logic [NB-1:0] lane_wr_n,
  input  logic          cs0_n,
  input  logic          cs1,
  input  logic          cs2_n,
  input  logic          oe_n,
  input  logic          ilv_mode,
  output logic [W-1:0]  dout,
  output logic          dout_en
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] base_r;
  logic [1:0]    cnt_r;
  logic          act_r;
  logic [NB-1:0] mask_r;
  logic [W-1:0]  din_r;
  logic [W-1:0]  rd_r;
  logic          vld_r;

  wire strobe = !start_ctl_n || !start_cpu_n;
  wire sel    = !cs0_n && cs1 && !cs2_n;
  wire [NB-1:0] wmask = !all_wr_n ? {NB{1'b1}} : (!byte_wr_n ? ~lane_wr_n : '0);
  wire [1:0] low = ilv_mode ? (base_r[1:0] ^ cnt_r) : (base_r[1:0] + cnt_r);
  wire [AW-1:0] eff = {base_r[AW-1:2], low};
  wire is_wr = act_r && (mask_r != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_r <= '0;
      cnt_r  <= '0;
      act_r  <= 1'b0;
      mask_r <= '0;
      din_r  <= '0;
      rd_r   <= '0;
      vld_r  <= 1'b0;
    end else begin
      if (strobe) begin
        act_r  <= sel;
        base_r <= addr;
        cnt_r  <= '0;
      end else if (!adv_n) begin
        cnt_r  <= cnt_r + 2'd1;
      end
      mask_r <= wmask;
      din_r  <= din;
      vld_r  <= act_r && !is_wr;
      if (act_r && !is_wr) rd_r <= mem[eff];
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (is_wr && mask_r[i]) mem[eff][i*BW +: BW] <= din_r[i*BW +: BW];
    end
  end

  assign dout_en = vld_r && !oe_n;
  assign dout    = rd_r;

  p_desel_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !sel) |=> ##1 !vld_r);
  p_valid_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_r |-> $past(act_r));
  p_write_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> !vld_r);
  p_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(base_r));
  p_cnt_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !adv_n && cnt_r == 2'd3) |=> cnt_r == 2'd0);
  p_load_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> cnt_r == 2'd0);
endmodule

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;
  localparam int AW = 6;
  localparam int W  = 36;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] din = '0;
  logic start_ctl_n = 1, start_cpu_n = 1, adv_n = 1, byte_wr_n = 1, all_wr_n = 1;
  logic [3:0] lane_wr_n = 4'hF;
  logic cs0_n = 0, cs1 = 1, cs2_n = 0, oe_n = 0, ilv_mode = 0;
  logic [W-1:0] dout;
  logic dout_en;

  int checks = 0, errors = 0;
  string req = "R1";

  logic [W-1:0] mem_m [64];
  logic m_act = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;
  logic [3:0] m_mask = '0;
  logic [W-1:0] m_din = '0;
  logic ev = 0;
  logic [W-1:0] ed = '0;

  always #4 clk = ~clk;

  sync_burst_sram dut_i (.clk, .rst_n, .addr, .din, .start_ctl_n, .start_cpu_n, .adv_n,
    .byte_wr_n, .all_wr_n, .lane_wr_n, .cs0_n, .cs1, .cs2_n, .oe_n, .ilv_mode, .dout, .dout_en);

  function automatic logic [W-1:0] dat(int a, int salt);
    return (36'(a) * 36'h1_2345) ^ (36'(salt) << 22) ^ 36'h5_A5A5;
  endfunction

  task automatic check_out();
    logic ee = ev && !oe_n;
    checks++;
    if (dout_en !== ee || (ee && dout !== ed)) begin
      errors++;
      $display("FAIL %s: en=%b dout=%h expected en=%b dout=%h", req, dout_en, dout, ee, ed);
    end
  endtask

  task automatic tick();
    logic [1:0] lo;
    logic [AW-1:0] ea;
    @(posedge clk);
    ev = 0;
    if (m_act) begin
      lo = ilv_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      ea = {m_base[AW-1:2], lo};
      if (m_mask != 0) begin
        for (int i = 0; i < 4; i++) if (m_mask[i]) mem_m[ea][i*9 +: 9] = m_din[i*9 +: 9];
      end else begin
        ev = 1; ed = mem_m[ea];
      end
    end
    if (!start_ctl_n || !start_cpu_n) begin
      m_act = !cs0_n && cs1 && !cs2_n; m_base = addr; m_cnt = 0;
    end else if (!adv_n) m_cnt = m_cnt + 2'd1;
    m_mask = !all_wr_n ? 4'hF : (!byte_wr_n ? ~lane_wr_n : 4'h0);
    m_din = din;
    #1;
    check_out();
  endtask

  task automatic idle_rd();
    start_ctl_n = 1; start_cpu_n = 1; adv_n = 1; all_wr_n = 1; byte_wr_n = 1; lane_wr_n = 4'hF;
  endtask

  task automatic desel();
    idle_rd(); start_ctl_n = 0; cs0_n = 1; tick(); cs0_n = 0; start_ctl_n = 1;
  endtask

  task automatic burst(input int a, input int beats, input bit cpu, input logic [3:0] lanes_n,
                       input bit bw_n, input bit gw_n, input int salt);
    for (int k = 0; k < beats; k++) begin
      start_ctl_n = (k == 0 && !cpu) ? 1'b0 : 1'b1;
      start_cpu_n = (k == 0 && cpu) ? 1'b0 : 1'b1;
      adv_n = (k == 0) ? 1'b1 : 1'b0;
      if (k == 0) addr = AW'(a);
      all_wr_n = gw_n; byte_wr_n = bw_n; lane_wr_n = lanes_n;
      din = dat(a * 4 + k, salt);
      tick();
    end
    idle_rd();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    req = "R1"; check_out();
    rst_n = 1;
    tick();
    // R7 fill the array with global writes, lane strobes inactive
    req = "R7";
    for (int b = 0; b < 16; b++) burst(b * 4, 4, b[0], 4'hF, b[1], 1'b0, 1);
    desel();
    // R3 linear reads from every start offset, R12 alternating strobes, R8 reads leave data
    ilv_mode = 0; req = "R3";
    for (int a = 0; a < 64; a++) begin burst(a, 4, a[0], 4'hF, 1, 1, 0); desel(); end
    // R4 interleaved reads
    ilv_mode = 1; req = "R4";
    for (int a = 0; a < 64; a++) begin burst(a, 4, a[0], 4'hF, 1, 1, 0); desel(); end
    // R5 wrap of a five-beat burst, then hold
    ilv_mode = 0; req = "R5";
    burst(6, 5, 0, 4'hF, 1, 1, 0);
    tick(); tick(); tick();
    adv_n = 0; tick(); adv_n = 1; tick();
    desel();
    // R6 every lane pattern, R11 read in the very next cycle
    for (int m = 0; m < 16; m++) begin
      req = "R6"; burst(5, 1, m[0], ~4'(m), 0, 1, 7 + m);
      req = "R11"; burst(5, 1, 0, 4'hF, 1, 1, 0);
      tick(); desel();
    end
    // R7 global write wins over byte controls
    req = "R7"; burst(9, 1, 0, 4'hF, 0, 0, 40); burst(9, 1, 0, 4'hF, 1, 1, 0); tick(); desel();
    // R8 neither write control: array unchanged
    req = "R8"; burst(9, 1, 0, 4'h0, 1, 1, 41); burst(9, 1, 0, 4'hF, 1, 1, 0); tick(); desel();
    // R9 each chip select inactive in turn
    req = "R9";
    for (int v = 0; v < 3; v++) begin
      burst(2, 1, 0, 4'hF, 1, 1, 0);
      start_ctl_n = 0; addr = 3;
      cs0_n = (v == 0); cs1 = (v != 1); cs2_n = (v == 2);
      tick();
      idle_rd(); cs0_n = 0; cs1 = 1; cs2_n = 0;
      tick(); tick();
    end
    // R10 output enable without a clock
    req = "R10";
    burst(12, 1, 0, 4'hF, 1, 1, 0); tick();
    @(negedge clk);
    oe_n = 1; #1; check_out();
    oe_n = 0; #1; check_out();
    tick(); desel(); tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule